// File: doc/BRIEF.md
# Fixed-Length RISC Instruction Decoder

This block turns one fetched 32-bit instruction into everything a small in-order core needs to run it. Four bytes arrive as fetched. The byte fetched first carries the most significant part of the word. The decoder finds the 6-bit operation code and sorts it into one of ten instruction classes. It then picks out up to three 5-bit register indices and builds the immediate in its final 32-bit form: zero-extended, sign-extended, moved to the upper half, assembled from two split pieces, or scaled to a byte offset for program-counter-relative transfers.

Control strobes tell the execution units what to do:
- register write-back, with a selector for the value to write;
- memory read or memory write;
- compare;
- jump, conditional jump, call and return.

For every address-forming instruction, the effective value is always first source register plus immediate. One adder therefore serves load address, load word and store word, and the core never looks at the instruction bits again. An operation code outside the supported ten raises an illegal flag, and every action output stays quiet.

The decoder is purely combinational. It holds no register file, no condition flag and no program counter.

Top module: `risc_insn_decode`

## Requirements
- R1: `fetch_bytes[7:0]` is the first fetched byte and becomes bits [31:24] of the instruction word; `fetch_bytes[31:24]` becomes bits [7:0]; `opcode` equals word bits [31:26].
- R2: Operation code 0x2A (load address) gives `op_class`=1, `reg_we`=1, `wb_sel`=1 (source plus immediate), `rd_idx`=word[25:21], `ra_idx`=word[20:16], `rb_idx`=0, and `imm` equal to word[15:0] zero-extended.
- R3: Operation code 0x06 (load high) gives `op_class`=2, `reg_we`=1, `wb_sel`=2 (immediate as is), `rd_idx`=word[25:21], `ra_idx`=0, `rb_idx`=0, and `imm`={word[15:0],16'h0000}.
- R4: Operation codes 0x00, 0x01, 0x03 and 0x04 give `op_class` 3, 4, 5 and 6 and `jump_en`=1. `call_en`=1 only for 0x01, and `jump_cond`=1 only for 0x03 and 0x04. All three register indices are 0, `reg_we`=0, and `imm` is word[25:0] sign-extended and multiplied by 4.
- R5: Operation code 0x21 (load word) gives `op_class`=8, `mem_rd`=1, `reg_we`=1, `wb_sel`=3 (memory data), `rd_idx`=word[25:21], `ra_idx`=word[20:16], and `imm` equal to word[15:0] sign-extended (0xFFF8 gives -8).
- R6: Operation code 0x35 (store word) gives `op_class`=7, `mem_wr`=1, `reg_we`=0, `rd_idx`=0, `ra_idx`=word[20:16] (base), `rb_idx`=word[15:11] (data), and `imm` equal to {word[25:21],word[10:0]} sign-extended from 16 bits.
- R7: Operation code 0x2F (compare) gives `op_class`=9, `cmp_en`=1, `ra_idx`=word[20:16], `rb_idx`=word[15:11], `rd_idx`=0, `imm`=0, and no write or memory strobe.
- R8: Operation code 0x11 (return) gives `op_class`=10, `ret_en`=1, `rb_idx`=word[15:11], `ra_idx`=0, `rd_idx`=0, `imm`=0, and `jump_en`=0.
- R9: Any other operation code gives `illegal`=1, `op_class`=0, `wb_sel`=0, all indices and `imm` equal to 0, and every strobe at 0. `illegal` is 0 for the ten supported codes.
- R10: For every operation code, at most one of `reg_we`, `mem_wr`, `cmp_en`, `jump_en` and `ret_en` is 1. Exactly one is 1 for each supported code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_bytes | input | 32 | Four fetched bytes, lane 0 (bits 7:0) fetched first |
| opcode | output | 6 | Operation code field of the assembled word |
| op_class | output | 4 | Instruction class code (0 = illegal, 1..10 as in the requirements) |
| illegal | output | 1 | Operation code is not one of the ten supported |
| rd_idx | output | 5 | Destination register index, 0 when nothing is written |
| ra_idx | output | 5 | First source / base register index |
| rb_idx | output | 5 | Second source: store data, compare operand or return target |
| imm | output | 32 | Final immediate or byte offset |
| reg_we | output | 1 | Register write-back strobe |
| wb_sel | output | 2 | Write-back source: 0 none, 1 ra plus imm, 2 imm, 3 memory |
| mem_rd | output | 1 | Memory read at ra plus imm |
| mem_wr | output | 1 | Memory write of rb at ra plus imm |
| cmp_en | output | 1 | Update the greater-than condition from ra and rb |
| jump_en | output | 1 | Program-counter-relative transfer by imm |
| jump_cond | output | 1 | Transfer depends on the condition |
| call_en | output | 1 | Transfer is a call |
| ret_en | output | 1 | Return through rb |

## Verification
The block holds no state, so a wrong table entry or a misplaced field slice shows up on the ports in the same evaluation as the word that exercises it. The errors worth watching for are:
- a byte lane swapped on the way in, which moves the operation code and turns legal words into illegal ones;
- an immediate built in the wrong format, which flips its sign bits or scales it wrongly;
- a table row with the wrong strobe, which produces two actions at once or none.

The bench therefore drives words taken from real instruction streams, including the negative offsets and extreme jump fields. It then sweeps every operation code with all operand bits set, so a stray index or a leaking strobe on an illegal code cannot hide behind zero operands.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

   localparam logic [5:0] OPC_JMP   = 6'h00;
   localparam logic [5:0] OPC_CALL  = 6'h01;
   localparam logic [5:0] OPC_JCOND = 6'h03;
   localparam logic [5:0] OPC_JGT   = 6'h04;
   localparam logic [5:0] OPC_LDHI  = 6'h06;
   localparam logic [5:0] OPC_RET   = 6'h11;
   localparam logic [5:0] OPC_LDW   = 6'h21;
   localparam logic [5:0] OPC_LDADR = 6'h2A;
   localparam logic [5:0] OPC_CMP   = 6'h2F;
   localparam logic [5:0] OPC_STW   = 6'h35;

   typedef enum logic [3:0] {
      CL_ILLEGAL = 4'd0,
      CL_LDADR   = 4'd1,
      CL_LDHI    = 4'd2,
      CL_JMP     = 4'd3,
      CL_CALL    = 4'd4,
      CL_JCOND   = 4'd5,
      CL_JGT     = 4'd6,
      CL_STW     = 4'd7,
      CL_LDW     = 4'd8,
      CL_CMP     = 4'd9,
      CL_RET     = 4'd10
   } iclass_e;

   typedef enum logic [1:0] {
      WB_NONE = 2'd0,
      WB_SUM  = 2'd1,
      WB_IMM  = 2'd2,
      WB_MEM  = 2'd3
   } wbsel_e;

   typedef enum logic [2:0] {
      IMM_NONE  = 3'd0,
      IMM_ZX    = 3'd1,
      IMM_HI    = 3'd2,
      IMM_SX    = 3'd3,
      IMM_SPLIT = 3'd4,
      IMM_JOFF  = 3'd5
   } immfmt_e;

   typedef struct packed {
      iclass_e cls;
      logic    legal;
      logic    reg_we;
      logic    mem_rd;
      logic    mem_wr;
      logic    cmp_en;
      logic    jump_en;
      logic    jump_cond;
      logic    call_en;
      logic    ret_en;
      wbsel_e  wb;
      immfmt_e imm_fmt;
      logic    use_rd;
      logic    use_ra;
      logic    use_rb;
   } ctrl_t;

endpackage

// File: rtl/rdec_word_pack.sv
module rdec_word_pack #(
   parameter int INSN_BYTES = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int INSN_W = INSN_BYTES * 8
) (
   input  logic [INSN_W-1:0] lanes,
   output logic [INSN_W-1:0] word
);

   if (INSN_BYTES < 1) begin : g_bad_bytes
      $error("rdec_word_pack: INSN_BYTES must be at least 1");
   end

   for (genvar i = 0; i < INSN_BYTES; i++) begin : g_lane
      if (BIG_ENDIAN) begin : g_msb_first
         assign word[(INSN_BYTES-1-i)*8 +: 8] = lanes[i*8 +: 8];
      end else begin : g_lsb_first
         assign word[i*8 +: 8] = lanes[i*8 +: 8];
      end
   end

endmodule

// File: rtl/rdec_opcode_table.sv
module rdec_opcode_table
   import rdec_pkg::*;
#(
   parameter int OPC_W = 6
) (
   input  logic [OPC_W-1:0] opc,
   output ctrl_t            ctrl
);

   if (OPC_W != 6) begin : g_bad_opc
      $error("rdec_opcode_table: the operation map is defined for 6-bit codes");
   end

   always_comb begin
      ctrl = '0;
      ctrl.cls = CL_ILLEGAL;
      ctrl.wb = WB_NONE;
      ctrl.imm_fmt = IMM_NONE;
      unique case (opc)
         OPC_LDADR: begin
            ctrl.cls = CL_LDADR;  ctrl.legal = 1'b1;
            ctrl.reg_we = 1'b1;   ctrl.wb = WB_SUM;   ctrl.imm_fmt = IMM_ZX;
            ctrl.use_rd = 1'b1;   ctrl.use_ra = 1'b1;
         end
         OPC_LDHI: begin
            ctrl.cls = CL_LDHI;   ctrl.legal = 1'b1;
            ctrl.reg_we = 1'b1;   ctrl.wb = WB_IMM;   ctrl.imm_fmt = IMM_HI;
            ctrl.use_rd = 1'b1;
         end
         OPC_JMP, OPC_CALL, OPC_JCOND, OPC_JGT: begin
            ctrl.legal = 1'b1;    ctrl.jump_en = 1'b1; ctrl.imm_fmt = IMM_JOFF;
            case (opc)
               OPC_JMP:   ctrl.cls = CL_JMP;
               OPC_CALL:  begin ctrl.cls = CL_CALL;  ctrl.call_en = 1'b1; end
               OPC_JCOND: begin ctrl.cls = CL_JCOND; ctrl.jump_cond = 1'b1; end
               default:   begin ctrl.cls = CL_JGT;   ctrl.jump_cond = 1'b1; end
            endcase
         end
         OPC_LDW: begin
            ctrl.cls = CL_LDW;    ctrl.legal = 1'b1;
            ctrl.reg_we = 1'b1;   ctrl.mem_rd = 1'b1;
            ctrl.wb = WB_MEM;     ctrl.imm_fmt = IMM_SX;
            ctrl.use_rd = 1'b1;   ctrl.use_ra = 1'b1;
         end
         OPC_STW: begin
            ctrl.cls = CL_STW;    ctrl.legal = 1'b1;
            ctrl.mem_wr = 1'b1;   ctrl.imm_fmt = IMM_SPLIT;
            ctrl.use_ra = 1'b1;   ctrl.use_rb = 1'b1;
         end
         OPC_CMP: begin
            ctrl.cls = CL_CMP;    ctrl.legal = 1'b1;
            ctrl.cmp_en = 1'b1;
            ctrl.use_ra = 1'b1;   ctrl.use_rb = 1'b1;
         end
         OPC_RET: begin
            ctrl.cls = CL_RET;    ctrl.legal = 1'b1;
            ctrl.ret_en = 1'b1;   ctrl.use_rb = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rdec_field_slice.sv
module rdec_field_slice
   import rdec_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32,
   parameter int JSHIFT = 2,
   localparam int BODY_W = 2 * REG_W + IMM_W,
   localparam int RA_LSB = IMM_W,
   localparam int RD_LSB = IMM_W + REG_W,
   localparam int RB_LSB = IMM_W - REG_W,
   localparam int JOFF_W = BODY_W
) (
   input  logic [BODY_W-1:0] body,
   input  immfmt_e           imm_fmt,
   input  logic              use_rd,
   input  logic              use_ra,
   input  logic              use_rb,
   output logic [REG_W-1:0]  rd,
   output logic [REG_W-1:0]  ra,
   output logic [REG_W-1:0]  rb,
   output logic [DATA_W-1:0] imm
);

   if (DATA_W < 2 * IMM_W) begin : g_bad_hi
      $error("rdec_field_slice: DATA_W too narrow for the upper-half immediate");
   end
   if (DATA_W < JOFF_W + JSHIFT) begin : g_bad_joff
      $error("rdec_field_slice: DATA_W too narrow for the scaled jump offset");
   end
   if (RB_LSB < 1) begin : g_bad_split
      $error("rdec_field_slice: the split offset needs IMM_W above REG_W");
   end

   logic [IMM_W-1:0]  short_imm;
   logic [IMM_W-1:0]  split_imm;
   logic [JOFF_W-1:0] joff;
   logic [DATA_W-1:0] zx_val, hi_val, sx_val, split_val, joff_val;

   assign short_imm = body[IMM_W-1:0];
   assign split_imm = {body[RD_LSB +: REG_W], body[RB_LSB-1:0]};
   assign joff      = body[JOFF_W-1:0];

   assign zx_val    = {{(DATA_W-IMM_W){1'b0}}, short_imm};
   assign hi_val    = {{(DATA_W-2*IMM_W){1'b0}}, short_imm, {IMM_W{1'b0}}};
   assign sx_val    = {{(DATA_W-IMM_W){short_imm[IMM_W-1]}}, short_imm};
   assign split_val = {{(DATA_W-IMM_W){split_imm[IMM_W-1]}}, split_imm};

   if (JSHIFT > 0) begin : g_scaled
      assign joff_val = {{(DATA_W-JOFF_W-JSHIFT){joff[JOFF_W-1]}}, joff, {JSHIFT{1'b0}}};
   end else begin : g_unscaled
      assign joff_val = {{(DATA_W-JOFF_W){joff[JOFF_W-1]}}, joff};
   end

   always_comb begin
      unique case (imm_fmt)
         IMM_ZX:    imm = zx_val;
         IMM_HI:    imm = hi_val;
         IMM_SX:    imm = sx_val;
         IMM_SPLIT: imm = split_val;
         IMM_JOFF:  imm = joff_val;
         default:   imm = '0;
      endcase
   end

   assign rd = use_rd ? body[RD_LSB +: REG_W] : '0;
   assign ra = use_ra ? body[RA_LSB +: REG_W] : '0;
   assign rb = use_rb ? body[RB_LSB +: REG_W] : '0;

   always_comb begin
      if (imm_fmt == IMM_SPLIT) begin
         p_split_sign_r6: assert (imm[DATA_W-1:IMM_W-1] == '0 || imm[DATA_W-1:IMM_W-1] == '1)
            else $error("split offset not sign-extended");
      end
   end

endmodule

// File: rtl/risc_insn_decode.sv
module risc_insn_decode
   import rdec_pkg::*;
#(
   parameter int INSN_BYTES = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   parameter int OPC_W      = 6,
   parameter int REG_W      = 5,
   parameter int IMM_W      = 16,
   parameter int DATA_W     = 32,
   localparam int INSN_W    = INSN_BYTES * 8,
   localparam int BODY_W    = INSN_W - OPC_W,
   localparam int JSHIFT    = $clog2(INSN_BYTES),
   localparam int CLS_W     = $bits(iclass_e),
   localparam int WB_W      = $bits(wbsel_e)
) (
   input  logic [INSN_W-1:0] fetch_bytes,
   output logic [OPC_W-1:0]  opcode,
   output logic [CLS_W-1:0]  op_class,
   output logic              illegal,
   output logic [REG_W-1:0]  rd_idx,
   output logic [REG_W-1:0]  ra_idx,
   output logic [REG_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] imm,
   output logic              reg_we,
   output logic [WB_W-1:0]   wb_sel,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              cmp_en,
   output logic              jump_en,
   output logic              jump_cond,
   output logic              call_en,
   output logic              ret_en
);

   if (INSN_W != OPC_W + 2 * REG_W + IMM_W) begin : g_bad_format
      $error("risc_insn_decode: field widths do not fill the instruction word");
   end

   logic [INSN_W-1:0] word;
   ctrl_t             ctrl;

   rdec_word_pack #(
      .INSN_BYTES (INSN_BYTES),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_pack (
      .lanes (fetch_bytes),
      .word  (word)
   );

   assign opcode = word[INSN_W-1 -: OPC_W];

   rdec_opcode_table #(
      .OPC_W (OPC_W)
   ) u_table (
      .opc  (opcode),
      .ctrl (ctrl)
   );

   rdec_field_slice #(
      .REG_W  (REG_W),
      .IMM_W  (IMM_W),
      .DATA_W (DATA_W),
      .JSHIFT (JSHIFT)
   ) u_fields (
      .body    (word[BODY_W-1:0]),
      .imm_fmt (ctrl.imm_fmt),
      .use_rd  (ctrl.use_rd),
      .use_ra  (ctrl.use_ra),
      .use_rb  (ctrl.use_rb),
      .rd      (rd_idx),
      .ra      (ra_idx),
      .rb      (rb_idx),
      .imm     (imm)
   );

   assign op_class  = ctrl.cls;
   assign illegal   = !ctrl.legal;
   assign reg_we    = ctrl.reg_we;
   assign wb_sel    = ctrl.wb;
   assign mem_rd    = ctrl.mem_rd;
   assign mem_wr    = ctrl.mem_wr;
   assign cmp_en    = ctrl.cmp_en;
   assign jump_en   = ctrl.jump_en;
   assign jump_cond = ctrl.jump_cond;
   assign call_en   = ctrl.call_en;
   assign ret_en    = ctrl.ret_en;

   always_comb begin
      p_one_action_r10: assert ($onehot0({reg_we, mem_wr, cmp_en, jump_en, ret_en}))
         else $error("more than one action strobe");
      if (illegal) begin
         p_illegal_quiet_r9: assert ({reg_we, mem_rd, mem_wr, cmp_en, jump_en, call_en, ret_en} == '0
                                     && imm == '0 && rd_idx == '0 && ra_idx == '0 && rb_idx == '0)
            else $error("illegal code leaked an action or operand");
      end
      if (jump_en) begin
         p_jump_noregs_r4: assert (rd_idx == '0 && ra_idx == '0 && rb_idx == '0
                                   && imm[0] == 1'b0 && !reg_we)
            else $error("relative transfer carries operands or unaligned offset");
      end
      if (wb_sel == WB_W'(WB_IMM)) begin
         p_hi_low_clear_r3: assert (imm[IMM_W-1:0] == '0 && reg_we)
            else $error("upper-half load leaves low bits set");
      end
      if (mem_wr) begin
         p_store_data_field_r6: assert (rb_idx == word[IMM_W-REG_W +: REG_W] && rd_idx == '0)
            else $error("store data register not taken from its field");
      end
      if (mem_rd) begin
         p_load_writes_r5: assert (reg_we && wb_sel == WB_W'(WB_MEM))
            else $error("memory read without write-back of its data");
      end
   end

endmodule

// File: tb/risc_insn_decode_test.sv
module risc_insn_decode_test;

   logic        clk = 1'b0;
   logic [31:0] fetch_bytes = '0;
   logic [5:0]  opcode;
   logic [3:0]  op_class;
   logic        illegal;
   logic [4:0]  rd_idx, ra_idx, rb_idx;
   logic [31:0] imm;
   logic        reg_we;
   logic [1:0]  wb_sel;
   logic        mem_rd, mem_wr, cmp_en, jump_en, jump_cond, call_en, ret_en;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   risc_insn_decode uut (
      .fetch_bytes (fetch_bytes),
      .opcode      (opcode),
      .op_class    (op_class),
      .illegal     (illegal),
      .rd_idx      (rd_idx),
      .ra_idx      (ra_idx),
      .rb_idx      (rb_idx),
      .imm         (imm),
      .reg_we      (reg_we),
      .wb_sel      (wb_sel),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .cmp_en      (cmp_en),
      .jump_en     (jump_en),
      .jump_cond   (jump_cond),
      .call_en     (call_en),
      .ret_en      (ret_en)
   );

   // strobe vector: {illegal, reg_we, mem_rd, mem_wr, cmp_en, jump_en, jump_cond, call_en, ret_en}
   function automatic logic [8:0] strobes();
      return {illegal, reg_we, mem_rd, mem_wr, cmp_en, jump_en, jump_cond, call_en, ret_en};
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // lane 0 carries the most significant byte of the word
   task automatic apply(input logic [31:0] w);
      @(negedge clk);
      fetch_bytes = {w[7:0], w[15:8], w[23:16], w[31:24]};
      #1;
   endtask

   task automatic expect_all(input string tag, input logic [31:0] w,
                             input logic [3:0] cls, input logic [8:0] stb, input logic [1:0] wb,
                             input logic [4:0] rd, input logic [4:0] ra, input logic [4:0] rb,
                             input logic [31:0] im);
      apply(w);
      check(tag, "opcode",   32'(opcode),   32'(w[31:26]));
      check(tag, "op_class", 32'(op_class), 32'(cls));
      check(tag, "strobes",  32'(strobes()), 32'(stb));
      check(tag, "wb_sel",   32'(wb_sel),   32'(wb));
      check(tag, "rd_idx",   32'(rd_idx),   32'(rd));
      check(tag, "ra_idx",   32'(ra_idx),   32'(ra));
      check(tag, "rb_idx",   32'(rb_idx),   32'(rb));
      check(tag, "imm",      imm,           im);
   endtask

   task automatic t_initial_r4;
      #1;
      check("R4", "initial zero word jump_en", 32'(jump_en), 32'd1);
      check("R4", "initial zero word imm", imm, 32'd0);
   endtask

   task automatic t_byte_order_r1;
      apply(32'hA8638608);
      check("R1", "opcode msb-first", 32'(opcode), 32'h2A);
      check("R1", "imm msb-first", imm, 32'h00008608);
      @(negedge clk);
      fetch_bytes = 32'hA8638608;   // lane 0 = 0x08: word 0x088663A8, code 0x02
      #1;
      check("R1", "reversed lanes opcode", 32'(opcode), 32'h02);
      check("R1", "reversed lanes illegal", 32'(illegal), 32'd1);
   endtask

   task automatic t_load_addr_r2;
      expect_all("R2", 32'hA884AB5C, 4'd1, 9'b0_1000_0000, 2'd1, 5'd4, 5'd4, 5'd0, 32'h0000AB5C);
      expect_all("R2", 32'hA9030000, 4'd1, 9'b0_1000_0000, 2'd1, 5'd8, 5'd3, 5'd0, 32'h00000000);
   endtask

   task automatic t_load_high_r3;
      expect_all("R3", 32'h1880000B, 4'd2, 9'b0_1000_0000, 2'd2, 5'd4, 5'd0, 5'd0, 32'h000B0000);
      expect_all("R3", 32'h1860FFFF, 4'd2, 9'b0_1000_0000, 2'd2, 5'd3, 5'd0, 5'd0, 32'hFFFF0000);
   endtask

   task automatic t_jumps_r4;
      expect_all("R4", 32'h1000000A, 4'd6, 9'b0_0000_1100, 2'd0, 5'd0, 5'd0, 5'd0, 32'h00000028);
      expect_all("R4", 32'h0400268A, 4'd4, 9'b0_0000_1010, 2'd0, 5'd0, 5'd0, 5'd0, 32'h00009A28);
      expect_all("R4", 32'h00000009, 4'd3, 9'b0_0000_1000, 2'd0, 5'd0, 5'd0, 5'd0, 32'h00000024);
      expect_all("R4", 32'h0FFFFFFF, 4'd5, 9'b0_0000_1100, 2'd0, 5'd0, 5'd0, 5'd0, 32'hFFFFFFFC);
      expect_all("R4", 32'h02000000, 4'd3, 9'b0_0000_1000, 2'd0, 5'd0, 5'd0, 5'd0, 32'hF8000000);
   endtask

   task automatic t_load_word_r5;
      expect_all("R5", 32'h8441FFF8, 4'd8, 9'b0_1100_0000, 2'd3, 5'd2, 5'd1, 5'd0, 32'hFFFFFFF8);
      expect_all("R5", 32'h8521FFFC, 4'd8, 9'b0_1100_0000, 2'd3, 5'd9, 5'd1, 5'd0, 32'hFFFFFFFC);
   endtask

   task automatic t_store_word_r6;
      expect_all("R6", 32'hD7E14FFC, 4'd7, 9'b0_0010_0000, 2'd0, 5'd0, 5'd1, 5'd9,  32'hFFFFFFFC);
      expect_all("R6", 32'hD401D00C, 4'd7, 9'b0_0010_0000, 2'd0, 5'd0, 5'd1, 5'd26, 32'h0000000C);
   endtask

   task automatic t_compare_r7;
      expect_all("R7", 32'hBC050000, 4'd9, 9'b0_0001_0000, 2'd0, 5'd0, 5'd5,  5'd0,  32'h0);
      expect_all("R7", 32'hBC1FF800, 4'd9, 9'b0_0001_0000, 2'd0, 5'd0, 5'd31, 5'd31, 32'h0);
   endtask

   task automatic t_return_r8;
      expect_all("R8", 32'h44004800, 4'd10, 9'b0_0000_0001, 2'd0, 5'd0, 5'd0, 5'd9,  32'h0);
      expect_all("R8", 32'h447FFFFF, 4'd10, 9'b0_0000_0001, 2'd0, 5'd0, 5'd0, 5'd31, 32'h0);
   endtask

   function automatic bit is_legal(input logic [5:0] op);
      case (op)
         6'h00, 6'h01, 6'h03, 6'h04, 6'h06, 6'h11, 6'h21, 6'h2A, 6'h2F, 6'h35: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic t_sweep_r9_r10;
      for (int op = 0; op < 64; op++) begin
         logic [5:0] o;
         int acts;
         o = 6'(op);
         apply({o, 26'h3FFFFFF});
         acts = int'(reg_we) + int'(mem_wr) + int'(cmp_en) + int'(jump_en) + int'(ret_en);
         if (is_legal(o)) begin
            check("R9",  $sformatf("op %h illegal", o), 32'(illegal), 32'd0);
            check("R10", $sformatf("op %h action count", o), 32'(acts), 32'd1);
         end else begin
            check("R9", $sformatf("op %h strobes", o), 32'(strobes()), 32'h100);
            check("R9", $sformatf("op %h class/wb", o), 32'({op_class, wb_sel}), 32'd0);
            check("R9", $sformatf("op %h indices", o), 32'({rd_idx, ra_idx, rb_idx}), 32'd0);
            check("R9", $sformatf("op %h imm", o), imm, 32'd0);
            check("R10", $sformatf("op %h action count", o), 32'(acts), 32'd0);
         end
      end
   endtask

   initial begin
      t_initial_r4();
      t_byte_order_r1();
      t_load_addr_r2();
      t_load_high_r3();
      t_jumps_r4();
      t_load_word_r5();
      t_store_word_r6();
      t_compare_r7();
      t_return_r8();
      t_sweep_r9_r10();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule